// File: doc/BRIEF.md
# SDRAM Burst Read Sequencer

This block reads from a 32-bit SDRAM array made of two 16-bit devices wired side by side. A requester presents a byte address with a valid strobe. The block accepts it when the ready output is high. It then opens the row with an activate command and issues a read with auto-precharge in the next cycle. It collects a burst of four words and hands each one back with a strobe and a beat number.

Every read closes its own row through auto-precharge. After the fourth data cycle the block keeps a per-bank wait counter, loaded from a configuration input. While that counter is non-zero, the bank cannot be opened again. The other bank is not affected. A 3-bit mapping code selects where the row, column and bank bits go on the thirteen multiplexed address pins. Codes with the top bit set are not usable at this data width and are flagged.

Top module: `sdram_burst_rd`

## Requirements
- R1: After a synchronous reset, and whenever the block is idle, the command pins read {cs_n,ras_n,cas_n,we_n} = 1111 (deselect) and `sdram_a` is 0. `rd_valid` and `rd_done` are 0. `req_ready` is 1 when the mapping code is valid.
- R2: A request is accepted on a rising edge where `req_valid` and `req_ready` are both 1. In the next cycle the command pins read 0011 (activate). In the cycle after that they read 0101 (read with auto-precharge).
- R3: For mapping codes 0, 1 and 2, call the code s. The bank bit is byte-address bit 21+s. In the activate cycle, `sdram_a[13:1]` equals address bits [21+s : 9+s]. In the read cycle it equals {bank, 1, address[11:1]}, so pin 12 carries the high auto-precharge bit.
- R4: For mapping code 3, the bank bit is address bit 19. In the activate cycle, `sdram_a[13:1]` equals address[21:9]. In the read cycle it equals {address[13:12], bank, 1, address[9:1]}, so pin 10 carries the high auto-precharge bit.
- R5: The four cycles after the read cycle are data cycles 1 to 4, and `sdram_dq` is sampled on the falling clock edge inside each one. Beat b (0..3) appears on `rd_data` with `rd_valid` = 1 and `rd_beat` = b in the cycle that follows data cycle b+1. `rd_done` is 1 only with beat 3.
- R6: `req_ready` is 0 from the activate cycle through data cycle 4, and the command pins read 1111 during the data cycles.
- R7: With `trp` = N, a request held for the bank just read sees `req_ready` = 0 for exactly N cycles after data cycle 4, and is then accepted.
- R8: A request for the other bank, if that bank has no wait pending, is ready in the first cycle after data cycle 4.
- R9: Mapping codes 4 to 7 set `cfg_err` = 1 and hold `req_ready` at 0, so no command is issued while a request is held.
- R10: A synchronous reset in the middle of an access returns the block to idle and deselect at the next edge, and it clears every bank's wait counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; data is sampled on its falling edge |
| rst | input | 1 | Synchronous reset, active high |
| map_code | input | 3 | Address-pin mapping code |
| trp | input | TRP_W | Wait cycles after a burst before the same bank reopens |
| req_valid | input | 1 | Read request valid |
| req_addr | input | 24 | Byte address of the request |
| req_ready | output | 1 | Request accepted on this edge when valid |
| cfg_err | output | 1 | Mapping code is not usable |
| sdram_cs_n | output | 1 | Chip select, active low |
| sdram_ras_n | output | 1 | Row strobe, active low |
| sdram_cas_n | output | 1 | Column strobe, active low |
| sdram_we_n | output | 1 | Write enable, active low |
| sdram_a | output | 13 | Multiplexed address pins 13..1 |
| sdram_dq | input | DATA_W | Read data from the two devices |
| rd_valid | output | 1 | Returned word valid |
| rd_data | output | DATA_W | Returned word |
| rd_beat | output | 2 | Beat number of the returned word |
| rd_done | output | 1 | Last beat of the burst |

## Verification
A sequencer that is out of step shows up on the command pins or the beat strobes within one or two cycles of the bad transition: a missing read after an activate, a data beat out of order, or `rd_done` arriving with the wrong beat. A wrong bank wait count only becomes visible when the same bank is requested again. There it changes the number of stalled cycles, so the bench sweeps every mapping code against every wait value and counts the stall exactly. A wrong pin mapping corrupts the row or column in its command cycle, and it also changes the data returned, because the bench's memory model builds each word from the pins it sees.

// File: rtl/sdram_burst_rd.sv
module sdram_burst_rd #(
  parameter int DATA_W = 32,
  parameter int TRP_W  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [2:0]        map_code,
  input  logic [TRP_W-1:0]  trp,
  input  logic              req_valid,
  input  logic [23:0]       req_addr,
  output logic              req_ready,
  output logic              cfg_err,
  output logic              sdram_cs_n,
  output logic              sdram_ras_n,
  output logic              sdram_cas_n,
  output logic              sdram_we_n,
  output logic [13:1]       sdram_a,
  input  logic [DATA_W-1:0] sdram_dq,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic [1:0]        rd_beat,
  output logic              rd_done
);

  typedef enum logic [1:0] {S_IDLE, S_ACT, S_RD, S_DATA} state_t;

  state_t             st;
  logic [23:0]        addr_q;
  logic [1:0]         code_q;
  logic               bank_q;
  logic [1:0]         beat_q;
  logic [TRP_W-1:0]   tap_cnt [2];
  logic [DATA_W-1:0]  dq_fall;

  function automatic logic bank_of(input logic [23:0] a, input logic [1:0] c);
    case (c)
      2'd0:    return a[21];
      2'd1:    return a[22];
      2'd2:    return a[23];
      default: return a[19];
    endcase
  endfunction

  logic req_bank;
  logic accept;
  assign req_bank  = bank_of(req_addr, map_code[1:0]);
  assign cfg_err   = map_code[2];
  assign req_ready = (st == S_IDLE) && !cfg_err && (tap_cnt[req_bank] == '0);
  assign accept    = req_valid && req_ready;

  logic [1:0]  row_shift;
  logic [23:0] row_src;
  logic [13:1] row_pins;
  logic [13:1] col_pins;
  assign row_shift = (code_q == 2'd3) ? 2'd0 : code_q;
  assign row_src   = addr_q >> row_shift;
  assign row_pins  = row_src[21:9];
  assign col_pins  = (code_q == 2'd3) ? {addr_q[13:12], bank_q, 1'b1, addr_q[9:1]}
                                      : {bank_q, 1'b1, addr_q[11:1]};

  assign {sdram_cs_n, sdram_ras_n, sdram_cas_n, sdram_we_n} =
      (st == S_ACT) ? 4'b0011 : (st == S_RD) ? 4'b0101 : 4'b1111;
  assign sdram_a = (st == S_ACT) ? row_pins : (st == S_RD) ? col_pins : '0;

  logic unused_bits;
  assign unused_bits = &{1'b0, addr_q[0], row_src[23:22], row_src[8:0]};

  always_ff @(negedge clk) dq_fall <= sdram_dq;

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= S_IDLE;
      addr_q   <= '0;
      code_q   <= '0;
      bank_q   <= 1'b0;
      beat_q   <= '0;
      rd_valid <= 1'b0;
      rd_done  <= 1'b0;
      rd_beat  <= '0;
      rd_data  <= '0;
      for (int b = 0; b < 2; b++) tap_cnt[b] <= '0;
    end else begin
      for (int b = 0; b < 2; b++)
        if (tap_cnt[b] != '0) tap_cnt[b] <= tap_cnt[b] - TRP_W'(1);

      rd_valid <= (st == S_DATA);
      rd_done  <= (st == S_DATA) && (beat_q == 2'd3);
      if (st == S_DATA) begin
        rd_data <= dq_fall;
        rd_beat <= beat_q;
      end

      case (st)
        S_IDLE: if (accept) begin
          addr_q <= req_addr;
          code_q <= map_code[1:0];
          bank_q <= req_bank;
          st     <= S_ACT;
        end
        S_ACT: st <= S_RD;
        S_RD: begin
          beat_q <= '0;
          st     <= S_DATA;
        end
        default: begin
          beat_q <= beat_q + 2'd1;
          if (beat_q == 2'd3) begin
            st               <= S_IDLE;
            tap_cnt[bank_q]  <= trp;
          end
        end
      endcase
    end
  end

endmodule

// File: rtl/sdram_burst_rd_chk.sv
module sdram_burst_rd_chk (
  input logic       clk,
  input logic       rst,
  input logic       req_valid,
  input logic       req_ready,
  input logic       cfg_err,
  input logic       sdram_cs_n,
  input logic       sdram_ras_n,
  input logic       sdram_cas_n,
  input logic       sdram_we_n,
  input logic       rd_valid,
  input logic [1:0] rd_beat,
  input logic       rd_done
);

  logic [3:0] cmd;
  assign cmd = {sdram_cs_n, sdram_ras_n, sdram_cas_n, sdram_we_n};

  // R2
  accept_act_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> (cmd == 4'b0011));

  // R2
  act_then_read_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd == 4'b0011) |=> (cmd == 4'b0101));

  // R6
  busy_no_ready_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd != 4'b1111) |-> !req_ready);

  // R9
  cfg_block_chk: assert property (@(posedge clk) disable iff (rst)
    cfg_err |-> !req_ready);

  // R5
  done_last_chk: assert property (@(posedge clk) disable iff (rst)
    rd_done |-> (rd_valid && rd_beat == 2'd3));

  // R5
  beat_step_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && rd_beat != 2'd3) |=> (rd_valid && rd_beat == $past(rd_beat) + 2'd1));

  // R10
  reset_idle_chk: assert property (@(posedge clk)
    rst |=> (cmd == 4'b1111 && !rd_valid));

endmodule

bind sdram_burst_rd sdram_burst_rd_chk u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
  .cfg_err(cfg_err), .sdram_cs_n(sdram_cs_n), .sdram_ras_n(sdram_ras_n),
  .sdram_cas_n(sdram_cas_n), .sdram_we_n(sdram_we_n), .rd_valid(rd_valid),
  .rd_beat(rd_beat), .rd_done(rd_done)
);

// File: tb/test_sdram_burst_rd.sv
`timescale 1ns/1ps
module test_sdram_burst_rd;
  localparam int DATA_W = 32;
  localparam int TRP_W  = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [2:0] map_code = 3'd0;
  logic [TRP_W-1:0] trp = '0;
  logic req_valid = 1'b0;
  logic [23:0] req_addr = '0;
  logic req_ready, cfg_err;
  logic cs_n, ras_n, cas_n, we_n;
  logic [13:1] sdram_a;
  logic [DATA_W-1:0] sdram_dq;
  logic rd_valid, rd_done;
  logic [DATA_W-1:0] rd_data;
  logic [1:0] rd_beat;
  logic [3:0] cmd;
  assign cmd = {cs_n, ras_n, cas_n, we_n};

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  sdram_burst_rd #(.DATA_W(DATA_W), .TRP_W(TRP_W)) i_sdram_burst_rd (
    .clk(clk), .rst(rst), .map_code(map_code), .trp(trp),
    .req_valid(req_valid), .req_addr(req_addr), .req_ready(req_ready),
    .cfg_err(cfg_err), .sdram_cs_n(cs_n), .sdram_ras_n(ras_n),
    .sdram_cas_n(cas_n), .sdram_we_n(we_n), .sdram_a(sdram_a),
    .sdram_dq(sdram_dq), .rd_valid(rd_valid), .rd_data(rd_data),
    .rd_beat(rd_beat), .rd_done(rd_done)
  );

  logic [13:1] m_row, m_col;
  initial begin
    sdram_dq = '0;
    m_row = '0;
    m_col = '0;
    forever begin
      @(posedge clk);
      if (cmd == 4'b0011) m_row = sdram_a;
      else if (cmd == 4'b0101) begin
        m_col = sdram_a;
        for (int k = 0; k < 4; k++) begin
          #1 sdram_dq = {k[1:0], m_row, 4'ha, m_col};
          @(posedge clk);
        end
        #1 sdram_dq = '0;
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic int bank_pos(input int code);
    return (code == 3) ? 19 : 21 + code;
  endfunction

  function automatic logic [13:1] exp_row(input logic [23:0] a, input int code);
    int s = (code == 3) ? 0 : code;
    return 13'((a >> (9 + s)) & 24'h1fff);
  endfunction

  function automatic logic [13:1] exp_col(input logic [23:0] a, input int code);
    logic bk = a[bank_pos(code)];
    if (code == 3)
      return 13'((((a >> 12) & 3) << 11) | (24'(bk) << 10) | (1 << 9) | ((a >> 1) & 24'h1ff));
    return 13'((24'(bk) << 12) | (1 << 11) | ((a >> 1) & 24'h7ff));
  endfunction

  task automatic do_read(input logic [23:0] a, input int code, input int exp_stall, input string stag);
    int stall = 0;
    string mtag = (code == 3) ? "R4" : "R3";
    logic [13:1] er = exp_row(a, code);
    logic [13:1] ec = exp_col(a, code);
    req_addr = a;
    req_valid = 1'b1;
    #1;
    while (!req_ready && stall < 40) begin
      @(negedge clk); #1; stall++;
    end
    chk(stall == exp_stall, stag, stall, exp_stall);
    @(negedge clk);
    req_valid = 1'b0;
    chk(cmd == 4'b0011, "R2 activate", cmd, 4'b0011);
    chk(sdram_a == er, {mtag, " row"}, sdram_a, er);
    chk(!req_ready, "R6 busy act", req_ready, 0);
    @(negedge clk);
    chk(cmd == 4'b0101, "R2 read", cmd, 4'b0101);
    chk(sdram_a == ec, {mtag, " col"}, sdram_a, ec);
    for (int c = 3; c <= 7; c++) begin
      @(negedge clk);
      if (c <= 6) chk(cmd == 4'b1111, "R6 data cmd", cmd, 4'b1111);
      if (c == 3) chk(!rd_valid, "R5 no early beat", rd_valid, 0);
      else begin
        logic [31:0] ed = {2'(c - 4), er, 4'ha, ec};
        chk(rd_valid && rd_beat == 2'(c - 4), "R5 beat", {rd_valid, rd_beat}, {1'b1, 2'(c - 4)});
        chk(rd_data == ed, "R5 data", rd_data, ed);
        chk(rd_done == (c == 7), "R5 done", rd_done, (c == 7));
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual expired expected finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    // R1
    chk(cmd == 4'b1111, "R1 deselect", cmd, 4'b1111);
    chk(sdram_a == 0, "R1 addr", sdram_a, 0);
    chk(!rd_valid && !rd_done, "R1 rd", {rd_valid, rd_done}, 0);
    chk(req_ready, "R1 ready", req_ready, 1);
    chk(!cfg_err, "R1 cfg", cfg_err, 0);
    @(negedge clk);

    for (int code = 0; code < 4; code++) begin
      for (int n = 0; n < 8; n++) begin
        logic [23:0] base = 24'((code * 8 + n) * 24'h3a5c93 + 24'h15a7);
        logic [23:0] a0 = base, a1 = base + 24'h0c48, a2 = base ^ 24'h0f0f0e;
        a0[bank_pos(code)] = 1'b0;
        a1[bank_pos(code)] = 1'b0;
        a2[bank_pos(code)] = 1'b1;
        map_code = 3'(code);
        trp = TRP_W'(n);
        do_read(a0, code, 0, "R8 free bank");
        do_read(a1, code, n, "R7 same bank stall");
        do_read(a2, code, 0, "R8 other bank");
        repeat (10) @(negedge clk);
      end
    end

    // R9
    for (int c = 4; c < 8; c++) begin
      map_code = 3'(c);
      req_valid = 1'b1;
      req_addr = 24'h123456;
      #1;
      chk(cfg_err, "R9 cfg_err", cfg_err, 1);
      chk(!req_ready, "R9 ready", req_ready, 0);
      repeat (3) begin
        @(negedge clk); #1;
        chk(cmd == 4'b1111, "R9 no command", cmd, 4'b1111);
      end
      req_valid = 1'b0;
    end
    map_code = 3'd0;
    #1 chk(!cfg_err, "R9 cfg clear", cfg_err, 0);
    @(negedge clk);

    // R10: reset during activate
    req_addr = 24'h00abc0;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk(cmd == 4'b0011, "R10 setup act", cmd, 4'b0011);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    #1;
    chk(cmd == 4'b1111, "R10 deselect", cmd, 4'b1111);
    chk(!rd_valid, "R10 rd_valid", rd_valid, 0);
    chk(req_ready, "R10 ready", req_ready, 1);
    repeat (4) begin
      @(negedge clk);
      chk(cmd == 4'b1111 && !rd_valid, "R10 stays idle", {cmd, rd_valid}, 5'b11110);
    end

    // R10: reset clears a pending bank wait
    trp = TRP_W'(7);
    do_read(24'h011110, 0, 0, "R10 first read");
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    do_read(24'h012220, 0, 0, "R10 window cleared");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule